// File: doc/BRIEF.md
# SD Host Data Buffer with Fill-Level Requests

This block is the word buffer that sits between the bus or DMA side of an SD host controller and the engine that moves data over the card's data lines. Writers push 32-bit words in, readers pop them out in the same order, and the block keeps a fill count that it compares against two programmable levels. One level decides when the buffer holds enough data for the bus side to come and drain it (card reads). The other decides when it has drained far enough that the bus side should refill it (card writes).

The comparison levels live in a 32-bit threshold word. Bits 11:0 set the refill level and bits 27:16 set the drain level. Bits 30:28 carry a burst-size code for the DMA engine. The block stores every bit of the word and returns it unchanged, including the spare bits. A one-cycle clear request empties the buffer and a busy flag shows while it runs. A sticky error flag records any push into a full buffer and any pop from an empty one.

Top module: `sd_data_fifo`

## Requirements
- R1: After reset the buffer is empty, the count is 0, full is low, the error flag is low, the threshold word reads 0, clear-busy is low, the refill request is high and the drain request is low.
- R2: Words leave in the order they entered. `rd_data` shows the oldest stored word without delay, and a pop advances to the next word.
- R3: An accepted push raises the count by one and an accepted pop lowers it by one. A push and a pop in the same cycle on a buffer that is neither full nor empty leave the count unchanged. Full is high exactly when the count equals DEPTH.
- R4: The drain request `rx_req` (status bit 0) is high exactly when the count is greater than threshold bits 27:16.
- R5: The refill request `tx_req` (status bit 1) is high exactly when the count is less than or equal to threshold bits 11:0.
- R6: The status word has empty in bit 2, full in bit 3 and the count zero-extended into bits 29:17. Bits 16:4, 31 and 30 read 0.
- R7: Writing the threshold word stores all 32 bits. The burst code in bits 30:28 and the spare bits 31 and 15:12 read back exactly as written.
- R8: A clear request makes `clr_busy` read 1 in the next cycle. At the end of that cycle both pointers and the count are zeroed, the error flag is cleared and `clr_busy` returns to 0. A push or pop offered while `clr_busy` is high is ignored.
- R9: A push into a full buffer with no pop in the same cycle is discarded and sets the error flag. The stored words and the count do not change.
- R10: A pop from an empty buffer sets the error flag and leaves the count at 0. The flag stays set until a clear completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push request |
| wr_data | input | 32 | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 32 | Oldest stored word |
| thr_we | input | 1 | Threshold word write strobe |
| thr_wdata | input | 32 | Threshold word write value |
| thr_q | output | 32 | Threshold word read-back |
| clr_req | input | 1 | Request a buffer clear |
| clr_busy | output | 1 | Clear in progress; reads as the self-clearing control bit |
| stat_q | output | 32 | Status word |
| rx_req | output | 1 | Drain request (count above drain level) |
| tx_req | output | 1 | Refill request (count at or below refill level) |
| xrun_err | output | 1 | Sticky overrun/underrun flag |

## Verification
The assertions check on every cycle that the two request outputs match their comparisons against the threshold fields, that full and empty are never high together, and that the count stays within DEPTH. They also check that a clear zeroes the count and the error flag and ends after one cycle, that the error flag stays set once raised, and that overrun and underrun set it. Only the bench scenarios can show data ordering, the refusal of the overrun word, read-back of the spare threshold bits, and the exact status layout.

// File: rtl/sd_data_fifo.sv
module sd_data_fifo #(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  input  logic        thr_we,
  input  logic [31:0] thr_wdata,
  output logic [31:0] thr_q,
  input  logic        clr_req,
  output logic        clr_busy,
  output logic [31:0] stat_q,
  output logic        rx_req,
  output logic        tx_req,
  output logic        xrun_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int STW = 13;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, empty, push_ok, pop_ok, bad_op;
  logic [STW-1:0] cnt_ext;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = rd_en && !empty && !clr_busy;
  assign push_ok = wr_en && (!full || pop_ok) && !clr_busy;
  assign bad_op  = !clr_busy && ((wr_en && !push_ok) || (rd_en && empty));
  assign cnt_ext = STW'(count);

  assign rd_data = mem[rd_ptr];
  assign rx_req  = {1'b0, cnt_ext} > {1'b0, thr_q[27:16]};
  assign tx_req  = {1'b0, cnt_ext} <= {1'b0, thr_q[11:0]};
  assign stat_q  = {2'b00, cnt_ext, 13'd0, full, empty, tx_req, rx_req};

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      xrun_err <= 1'b0;
      clr_busy <= 1'b0;
    end else if (clr_busy) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      xrun_err <= 1'b0;
      clr_busy <= 1'b0;
    end else begin
      clr_busy <= clr_req;
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (bad_op) xrun_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_we) thr_q <= thr_wdata;
  end
endmodule

module sd_data_fifo_chk #(
  parameter int DEPTH = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [31:0] thr_q,
  input logic        clr_busy,
  input logic [31:0] stat_q,
  input logic        rx_req,
  input logic        tx_req,
  input logic        xrun_err
);
  logic [12:0] cnt;
  logic        full, empty;
  assign cnt   = stat_q[29:17];
  assign full  = stat_q[3];
  assign empty = stat_q[2];

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 13'(DEPTH));
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !full && !empty && !clr_busy) |=> $stable(stat_q[29:17]));
  p_rx_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req == (cnt > {1'b0, thr_q[27:16]}));
  p_tx_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req == (cnt <= {1'b0, thr_q[11:0]}));
  p_full_empty_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  p_clear_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> (cnt == 13'd0 && !clr_busy && !xrun_err));
  p_overrun_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en && !clr_busy) |=> (xrun_err && full));
  p_underrun_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !clr_busy) |=> (xrun_err && empty));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xrun_err && !clr_busy) |=> xrun_err);
endmodule

bind sd_data_fifo sd_data_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .thr_q(thr_q),
  .clr_busy(clr_busy), .stat_q(stat_q), .rx_req(rx_req), .tx_req(tx_req),
  .xrun_err(xrun_err)
);

// File: tb/sd_data_fifo_tb_top.sv
`timescale 1ns/1ps
module sd_data_fifo_tb_top;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, thr_we = 1'b0, clr_req = 1'b0;
  logic [31:0] wr_data = '0, thr_wdata = '0;
  logic [31:0] rd_data, thr_q, stat_q;
  logic        clr_busy, rx_req, tx_req, xrun_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sd_data_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .thr_q(thr_q), .clr_req(clr_req), .clr_busy(clr_busy), .stat_q(stat_q),
    .rx_req(rx_req), .tx_req(tx_req), .xrun_err(xrun_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(input int n, input int rxw, input int txw);
    logic [12:0] c = 13'(n);
    return {2'b00, c, 13'd0, (n == DEPTH), (n == 0), (n <= txw), (n > rxw)};
  endfunction

  task automatic push(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pop_expect(input logic [31:0] d, input string req);
    @(negedge clk);
    check(req, rd_data, d);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic soft_clear();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 status", stat_q, exp_stat(0, 0, 0));
    check("R1 thr", thr_q, 32'h0);
    check("R1 flags", {28'd0, clr_busy, xrun_err, tx_req, rx_req}, 32'h2);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(32'hA000_0000 + i);
    check("R3 count5", stat_q, exp_stat(5, 0, 0));
    for (int i = 0; i < 5; i++) pop_expect(32'hA000_0000 + i, "R2 order");
    check("R3 drained", stat_q, exp_stat(0, 0, 0));
  endtask

  task automatic t_simul();
    push(32'h11); push(32'h22);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; wr_data = 32'h33;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R3 simul count", stat_q, exp_stat(2, 0, 0));
    pop_expect(32'h22, "R2 after simul");
    pop_expect(32'h33, "R2 after simul");
  endtask

  task automatic t_thresholds();
    logic [31:0] w = {1'b1, 3'b101, 12'd3, 4'hA, 12'd2};
    @(negedge clk); thr_we = 1'b1; thr_wdata = w;
    @(negedge clk); thr_we = 1'b0;
    check("R7 readback", thr_q, w);
    check("R5 R4 empty", stat_q, exp_stat(0, 3, 2));
    for (int n = 1; n <= 5; n++) begin
      push(32'(n));
      check("R4 rx_req", {31'd0, rx_req}, {31'd0, n > 3});
      check("R5 tx_req", {31'd0, tx_req}, {31'd0, n <= 2});
      check("R6 layout", stat_q, exp_stat(n, 3, 2));
    end
    soft_clear();
    check("R8 after clear", stat_q, exp_stat(0, 3, 2));
    @(negedge clk); thr_we = 1'b1; thr_wdata = 32'h0;
    @(negedge clk); thr_we = 1'b0;
  endtask

  task automatic t_overrun();
    for (int i = 0; i < DEPTH; i++) push(32'h5000 + i);
    check("R3 full", stat_q, exp_stat(DEPTH, 0, 0));
    check("R9 no err yet", {31'd0, xrun_err}, 32'd0);
    push(32'hDEAD_BEEF);
    check("R9 err", {31'd0, xrun_err}, 32'd1);
    check("R9 count kept", stat_q, exp_stat(DEPTH, 0, 0));
    for (int i = 0; i < DEPTH; i++) pop_expect(32'h5000 + i, "R9 contents");
    check("R3 empty again", stat_q, exp_stat(0, 0, 0));
    soft_clear();
    check("R8 err cleared", {31'd0, xrun_err}, 32'd0);
  endtask

  task automatic t_underrun();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R10 err", {31'd0, xrun_err}, 32'd1);
    check("R10 count", stat_q, exp_stat(0, 0, 0));
    push(32'h77);
    check("R10 sticky", {31'd0, xrun_err}, 32'd1);
    check("R3 count1", stat_q, exp_stat(1, 0, 0));
  endtask

  task automatic t_clear();
    push(32'h1); push(32'h2);
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    check("R8 busy", {31'd0, clr_busy}, 32'd1);
    check("R8 still held", stat_q, exp_stat(3, 0, 0));
    wr_en = 1'b1; wr_data = 32'h99; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R8 done", {31'd0, clr_busy}, 32'd0);
    check("R8 emptied", stat_q, exp_stat(0, 0, 0));
    check("R8 err zero", {31'd0, xrun_err}, 32'd0);
    push(32'hC0DE);
    pop_expect(32'hC0DE, "R8 pointers reset");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_simul();
    t_thresholds();
    t_overrun();
    t_underrun();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule